// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Controller

This block is the device-side command logic of a serial flash, limited to the path that erases one 64KB block. It watches chip select, serial clock and serial data in, which it samples with its own system clock. From the bit stream it recognises three instructions: write enable, status read and block erase. It holds a write-enable latch, a busy flag and four protection bits. An accepted erase starts a self-timed busy period whose length is a parameter. At the start of that period the block announces the target block to the storage array with a one-cycle strobe.

The link works in SPI mode 0. Data in is taken on the rising serial-clock edge and data out changes on the falling edge, most significant bit first. A block erase is executed only when all of the following hold:
- the frame carried exactly the opcode and a 24-bit address;
- chip select rose right after the last address bit;
- the write-enable latch was already set;
- the block is not protected.

The protection bits are loaded through a direct write port. While the erase is running, only status reads have any effect.

Top module: `sflash_blk_erase`

## Requirements
- R1: A frame of exactly 8 bits carrying 06h, closed by chip select rising, sets the write-enable latch. A frame of any other length leaves the latch unchanged.
- R2: An accepted block erase (D8h followed by a 24-bit address, MSB first) raises `erase_stb` for exactly one clock cycle. On that cycle `erase_blk` equals address bits [20:16].
- R3: An erase frame whose length is not exactly 32 bits when chip select rises does not execute.
- R4: An erase frame received while the write-enable latch is clear does not execute.
- R5: After an accepted erase, the busy flag (status bit 0) is 1 for exactly TBE clock cycles, starting with the cycle of the strobe.
- R6: The write-enable latch clears one cycle before the busy flag clears, so both read 0 after completion.
- R7: With protection value P (status bits 5..2) nonzero, the top 2^(P-1) of the 32 blocks are protected; all blocks are protected when P-1 is 5 or more. An erase to a protected block does not execute and busy stays 0.
- R8: Opcode 05h returns the status byte {2'b00, P[3:0], latch, busy}, MSB first. Each bit is driven on a falling serial-clock edge. The byte repeats for as long as chip select stays low.
- R9: While busy, write-enable and erase frames are ignored; status reads still work.
- R10: After reset the latch, busy flag, protection bits, `miso` and `erase_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| bp_we | input | 1 | Write strobe for the protection bits |
| bp_wdata | input | 4 | New protection value |
| miso | output | 1 | Serial data out (status bits) |
| erase_stb | output | 1 | One-cycle erase request to the array |
| erase_blk | output | 5 | Index of the block to erase |

## Verification
On every cycle, the embedded assertions check several invariants:
- the strobe lasts one cycle and coincides with busy;
- the strobe is preceded by a set latch, an idle timer and an unprotected target;
- the latch is already clear when busy falls;
- data out changes only after a falling serial-clock edge or while deselected.

Other behaviour needs framed stimulus, and the bench's scenarios provide it:
- frames of wrong length being refused;
- the exact protection boundary;
- commands being ignored during busy;
- the repeating content of the status byte.

A behavioural reference model compares `miso`, `erase_stb` and `erase_blk` against the design on every clock.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_ERASE = 8'hD8;
    localparam int OPC_W = 8;
    localparam int STAT_W = 8;
endpackage

// File: rtl/sfe_pin_edge.sv
module sfe_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);
    typedef struct packed {
        logic cs;
        logic sck;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d.cs  = cs_n;
        pin_d.sck = sck;
        sck_rise  = sck & ~pin_q.sck;
        sck_fall  = ~sck & pin_q.sck;
        cs_rise   = cs_n & ~pin_q.cs;
        cs_fall   = ~cs_n & pin_q.cs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q.cs  <= 1'b1;
            pin_q.sck <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end
endmodule

// File: rtl/sfe_prot_chk.sv
module sfe_prot_chk #(
    parameter int BLK_W = 5,
    parameter int BP_W  = 4
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [BP_W-1:0]  bp,
    output logic             hit
);
    localparam logic [31:0] NBLK = 32'(1) << BLK_W;

    logic [31:0] span;

    always_comb begin
        span = '0;
        if (bp != '0) begin
            if (32'(bp) - 32'd1 >= 32'(BLK_W)) span = NBLK;
            else span = 32'(1) << (32'(bp) - 32'd1);
        end
        hit = (32'(blk) + span) >= NBLK;
    end
endmodule

// File: rtl/sfe_busy_timer.sv
module sfe_busy_timer #(
    parameter int TBE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic wel_clr
);
    localparam int CNT_W = $clog2(TBE + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) cnt_d = CNT_W'(TBE);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        busy    = (cnt_q != '0);
        wel_clr = (cnt_q == CNT_W'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: count never exceeds the programmed duration
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TBE));
    // R9: a new cycle never starts on top of a running one
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/sflash_blk_erase.sv
module sflash_blk_erase #(
    parameter int ADDR_W  = 24,
    parameter int BLK_LSB = 16,
    parameter int BLK_W   = 5,
    parameter int BP_W    = 4,
    parameter int TBE     = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             bp_we,
    input  logic [BP_W-1:0]  bp_wdata,
    output logic             miso,
    output logic             erase_stb,
    output logic [BLK_W-1:0] erase_blk
);
    import sfe_pkg::*;

    localparam int FRAME_BITS = OPC_W + ADDR_W;
    localparam int BIT_W      = $clog2(FRAME_BITS + 1) + 1;

    typedef struct packed {
        logic [BIT_W-1:0]      bits;
        logic [FRAME_BITS-1:0] sh;
        logic                  rd;
        logic [2:0]            oidx;
        logic                  dout;
        logic                  wel;
        logic [BP_W-1:0]       bp;
        logic                  stb;
        logic [BLK_W-1:0]      blk;
    } st_t;

    st_t st_d, st_q;

    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic busy, wel_clr, start, hit;
    logic [BLK_W-1:0]  blk_in;
    logic [STAT_W-1:0] stat;

    sfe_pin_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall)
    );

    sfe_busy_timer #(.TBE(TBE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .wel_clr (wel_clr)
    );

    sfe_prot_chk #(.BLK_W(BLK_W), .BP_W(BP_W)) u_prot (
        .blk (blk_in),
        .bp  (st_q.bp),
        .hit (hit)
    );

    assign blk_in = st_q.sh[BLK_LSB +: BLK_W];
    assign stat   = STAT_W'({st_q.bp, st_q.wel, busy});

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        start    = 1'b0;

        if (bp_we) st_d.bp = bp_wdata;

        // framing: shift on rising SCK, restart on CS falling
        if (cs_fall) begin
            st_d.bits = '0;
            st_d.rd   = 1'b0;
            st_d.oidx = '0;
        end else if (!cs_n && sck_rise) begin
            st_d.sh = {st_q.sh[FRAME_BITS-2:0], mosi};
            if (st_q.bits != '1) st_d.bits = st_q.bits + 1'b1;
            if (st_q.bits == BIT_W'(OPC_W - 1) && {st_q.sh[OPC_W-2:0], mosi} == OP_RDSR)
                st_d.rd = 1'b1;
        end

        // status output on falling SCK
        if (cs_n) begin
            st_d.dout = 1'b0;
        end else if (sck_fall && st_q.rd) begin
            st_d.dout = stat[3'd7 - st_q.oidx];
            st_d.oidx = st_q.oidx + 1'b1;
        end

        // instruction execution on CS rising
        if (wel_clr) begin
            st_d.wel = 1'b0;
        end else if (cs_rise && !busy) begin
            if (st_q.bits == BIT_W'(OPC_W) && st_q.sh[OPC_W-1:0] == OP_WREN)
                st_d.wel = 1'b1;
            if (st_q.bits == BIT_W'(FRAME_BITS) &&
                st_q.sh[FRAME_BITS-1 -: OPC_W] == OP_ERASE && st_q.wel && !hit) begin
                start    = 1'b1;
                st_d.stb = 1'b1;
                st_d.blk = blk_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso      = st_q.dout;
    assign erase_stb = st_q.stb;
    assign erase_blk = st_q.blk;

    // R2: the array request is a single-cycle pulse
    p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |=> !erase_stb);
    // R5: busy is reported from the strobe cycle onward
    p_stb_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> busy);
    // R4: an erase needs the latch set beforehand
    p_stb_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> $past(st_q.wel));
    // R9: no erase is accepted while the previous one runs
    p_stb_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> $past(!busy));
    // R7: protected targets never produce a strobe
    p_stb_unprot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> $past(!hit));
    // R6: latch already clear when busy drops
    p_wel_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(st_q.wel));
    // R8: data out moves only after a falling SCK or while deselected
    p_do_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_fall) || $past(cs_n)));
endmodule

// File: tb/sflash_blk_erase_tb_top.sv
module sflash_blk_erase_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TBE = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic bp_we = 1'b0;
    logic [3:0] bp_wdata = 4'h0;
    logic miso, erase_stb;
    logic [4:0] erase_blk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int stb_cnt = 0;
    int last_blk = -1;

    sflash_blk_erase #(.TBE(TBE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .bp_we(bp_we), .bp_wdata(bp_wdata), .miso(miso),
        .erase_stb(erase_stb), .erase_blk(erase_blk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_cnt;
    bit m_wel, m_rd, m_do, m_stb, m_sck_p, m_cs_p;
    bit [3:0] m_bp;
    int m_oidx, m_blk;
    bit bq[$];

    function automatic int qval(int from, int n);
        int v = 0;
        for (int i = 0; i < n; i++) v = (v << 1) | int'(bq[from + i]);
        return v;
    endfunction

    function automatic bit is_prot(int blk, int bp);
        int span;
        if (bp == 0) return 0;
        span = (bp - 1 >= 5) ? 32 : (1 << (bp - 1));
        return blk >= 32 - span;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_wel = 0; m_rd = 0; m_do = 0; m_stb = 0;
            m_sck_p = 0; m_cs_p = 1; m_bp = 0; m_oidx = 0; m_blk = 0;
            bq.delete();
        end else begin
            bit busy0, wel0, sr, sf, cr, cf;
            bit [3:0] bp0;
            bit [7:0] st;
            busy0 = (m_cnt > 0);
            wel0 = m_wel;
            bp0 = m_bp;
            st = {2'b00, m_bp, m_wel, busy0};
            sr = sck && !m_sck_p;
            sf = !sck && m_sck_p;
            cr = cs_n && !m_cs_p;
            cf = !cs_n && m_cs_p;
            m_stb = 0;
            if (bp_we) m_bp = bp_wdata;
            if (cf) begin
                bq.delete(); m_rd = 0; m_oidx = 0;
            end else if (!cs_n && sr) begin
                bq.push_back(mosi);
                if (bq.size() == 8 && qval(0, 8) == 8'h05) m_rd = 1;
            end
            if (cs_n) m_do = 0;
            else if (sf && m_rd) begin
                m_do = st[7 - m_oidx];
                m_oidx = (m_oidx + 1) % 8;
            end
            if (busy0) begin
                if (m_cnt == 2) m_wel = 0;
                m_cnt--;
            end else if (cr) begin
                if (bq.size() == 8 && qval(0, 8) == 8'h06) m_wel = 1;
                if (bq.size() == 32 && qval(0, 8) == 8'hD8 && wel0 &&
                    !is_prot(qval(11, 5), int'(bp0))) begin
                    m_cnt = TBE; m_stb = 1; m_blk = qval(11, 5);
                end
            end
            m_sck_p = sck;
            m_cs_p = cs_n;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (miso !== m_do || erase_stb !== m_stb || (m_stb && erase_blk !== 5'(m_blk))) begin
                errors++;
                $display("FAIL R2,R5,R6,R8 model mismatch t=%0t: miso=%b/%b stb=%b/%b blk=%0d/%0d",
                         $time, miso, m_do, erase_stb, m_stb, erase_blk, m_blk);
            end
            if (erase_stb) begin
                stb_cnt++;
                last_blk = int'(erase_blk);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xbit(input bit b, output bit r);
        mosi = b;
        repeat (2) @(negedge clk);
        r = miso;
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame(input logic [39:0] d, input int n, input int rbytes, output int rv);
        bit r;
        rv = 0;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) xbit(d[n - 1 - i], r);
        for (int i = 0; i < rbytes * 8; i++) begin
            xbit(1'b0, r);
            rv = (rv << 1) | int'(r);
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rdsr(input int nb, output int v);
        frame(40'h05, 8, nb, v);
    endtask

    task automatic cmd(input logic [39:0] d, input int n);
        int dummy;
        frame(d, n, 0, dummy);
    endtask

    task automatic set_bp(input logic [3:0] v);
        bp_wdata = v;
        bp_we = 1'b1;
        @(negedge clk);
        bp_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        check("R10 miso after reset", int'(miso), 0);
        check("R10 erase_stb after reset", int'(erase_stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rdsr(1, v);
        check("R10 status after reset", v, 8'h00);

        cmd(40'hD8030000, 32);
        check("R4 no erase without latch", stb_cnt, 0);
        rdsr(1, v);
        check("R4 status unchanged", v, 8'h00);

        cmd(40'h0D, 9);
        rdsr(1, v);
        check("R1 nine-bit write-enable ignored", v, 8'h00);
        cmd(40'h06, 8);
        rdsr(1, v);
        check("R1 latch set", v, 8'h02);

        cmd(40'hD81A2345 >> 1, 31);
        check("R3 short erase frame ignored", stb_cnt, 0);
        cmd({40'hD81A2345, 1'b0}, 33);
        check("R3 long erase frame ignored", stb_cnt, 0);

        set_bp(4'd1);
        rdsr(1, v);
        check("R8 protection bits in status", v, 8'h06);
        cmd(40'hD81F0000, 32);
        check("R7 protected top block refused", stb_cnt, 0);

        cmd(40'hD81A2345, 32);
        check("R2 erase strobe count", stb_cnt, 1);
        check("R2 erase block index", last_blk, 26);
        rdsr(2, v);
        check("R5 busy and repeated status bytes R8", v, 16'h0707);
        cmd(40'h06, 8);
        cmd(40'hD8050000, 32);
        check("R9 erase during busy ignored", stb_cnt, 1);
        rdsr(1, v);
        check("R9 status read during busy", v, 8'h07);

        repeat (TBE + 50) @(negedge clk);
        rdsr(1, v);
        check("R6 latch and busy cleared", v, 8'h04);

        set_bp(4'd6);
        cmd(40'h06, 8);
        cmd(40'hD8000000, 32);
        check("R7 all blocks protected", stb_cnt, 1);
        rdsr(1, v);
        check("R7 busy stays clear", v, 8'h1A);

        set_bp(4'd5);
        cmd(40'hD8100000, 32);
        check("R7 block 16 protected by 5", stb_cnt, 1);
        cmd(40'hD80F0000, 32);
        check("R7 block 15 allowed by 5", stb_cnt, 2);
        check("R2 block index 15", last_blk, 15);
        repeat (TBE + 50) @(negedge clk);
        rdsr(1, v);
        check("R6 completion status", v, 8'h14);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule